// File: doc/BRIEF.md
# Video Table Address Masking Unit

This block forms the 17-bit video-memory address for one table lookup of a display controller. A lookup is presented as a single-cycle request carrying a display mode, a table selector and an internal index. The index is padded into a 17-bit word: fixed ones fill the bits above the table's own width, and certain sprite-table bits are fixed at zero. The base registers for the selected table are packed into a second 17-bit word, with ones filling every bit below the field that the registers supply. The output address is the bitwise AND of these two words. It is not a sum and it is not a concatenation.

Because the combination is an AND, software can clear base-register bits that would normally be one. The lookup then folds onto a smaller region, so several tables or sprite groups share the same entries. Clearing an upper base bit that the table needs moves the whole table to a different place. The address is registered, and it appears one clock after the request together with a valid flag. A mode and table pair that the controller does not support returns address zero and raises an error flag.

Top module: `vtab_addr_unit`

## Requirements
- R1: Synchronous active-high reset drives `valid_o`, `err_o` and `addr_o` to zero.
- R2: A request sampled on a clock edge makes `valid_o` high after that edge, for exactly one cycle. A cycle without a request leaves `valid_o` and `err_o` low after the next edge.
- R3: Sprite attribute table (table code 3, any mode code 0..3):
  - `addr_o[16:9]` = {`spr_hi_i`, `spr_lo_i`}[9:2].
  - `addr_o[8:7]` = 0.
  - `addr_o[6:0]` = `idx_i[6:0]`.
- R4: Sprite colour table (table code 4, any mode): `addr_o[16:10]` comes from the sprite registers, `addr_o[9]` = 0, and `addr_o[8:0]` = `idx_i[8:0]` ANDed with ones below A9. Clearing sprite base bits A8 and A7 makes indices i, i+128, i+256 and i+384 map to one address.
- R5: When sprite base bit A9 is zero, attribute index i and colour index i (i < 128) give the same address, provided A8 and A7 are one.
- R6: Pattern table (table code 1, tile modes 0 and 1): the address is {`pat_base_i`, 11 ones} AND {4 ones, `idx_i[12:0]`}. Clearing base bits A12 and A11 makes indices i, i+2048, i+4096 and i+6144 map to one address.
- R7: Colour table (table code 2, tile modes 0 and 1): the address is {`col_hi_i`, `col_lo_i`, 5 ones} AND {4 ones, `idx_i[12:0]`}. `col_lo_i` supplies A13..A5 and `col_hi_i` supplies A16..A14.
- R8: Name table (table code 0) in the 4-bit bitmap mode (mode code 2): the address is {`name_base_i`, 10 ones} AND {2 ones, `idx_i[14:0]`}.
- R9: Name table in the 8-bit bitmap mode (mode code 3): the name register is shifted. `name_base_i[5:0]` supplies A16..A11, `name_base_i[6]` is ignored, and the address is {`name_base_i[5:0]`, 11 ones} AND {1 one, `idx_i[15:0]`}.
- R10: Any other pair returns `addr_o` = 0 with `err_o` = 1 and `valid_o` = 1. This covers table codes 5..7, the name table in modes 0 and 1, and the pattern and colour tables in modes 2 and 3.
- R11: Index bits at or above the selected table's index width have no effect on the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Lookup request, one cycle |
| mode_i | input | 2 | Display mode code |
| tbl_i | input | 3 | Table selector code |
| idx_i | input | 16 | Internal lookup index |
| name_base_i | input | 7 | Name table base register |
| pat_base_i | input | 6 | Pattern table base, A16..A11 |
| col_lo_i | input | 9 | Colour table base, A13..A5 |
| col_hi_i | input | 3 | Colour table base, A16..A14 |
| spr_lo_i | input | 8 | Sprite table base, A14..A7 |
| spr_hi_i | input | 2 | Sprite table base, A16..A15 |
| valid_o | output | 1 | Address valid, one cycle after request |
| err_o | output | 1 | Unsupported mode/table pair |
| addr_o | output | 17 | Registered video-memory address |

## Verification
The folding cases are the hardest to reach. They only show up as two different requests that return the same address, and only when base bits that normally hold ones have been cleared on purpose. The overlap of the attribute and colour tables under a cleared A9 is the clearest example. The bench sets up these register values directly: it issues the colliding index pairs back to back and compares the two addresses it gets. This is done on top of a sweep over every mode and table code, using several index patterns and register patterns, each checked against an arithmetic model.

// File: rtl/vtab_pkg.sv
package vtab_pkg;
  localparam int ADDR_W = 17;
  localparam int IDX_W  = 16;

  localparam logic [1:0] MD_TILE_A = 2'd0;
  localparam logic [1:0] MD_TILE_B = 2'd1;
  localparam logic [1:0] MD_BMP4   = 2'd2;
  localparam logic [1:0] MD_BMP8   = 2'd3;

  localparam logic [2:0] TB_NAME = 3'd0;
  localparam logic [2:0] TB_PGEN = 3'd1;
  localparam logic [2:0] TB_COLR = 3'd2;
  localparam logic [2:0] TB_SATR = 3'd3;
  localparam logic [2:0] TB_SCOL = 3'd4;

  // index widths per table
  localparam int SATR_IW = 7;
  localparam int SCOL_IW = 9;
  localparam int TILE_IW = 13;
  localparam int BMP4_IW = 15;
  localparam int BMP8_IW = 16;

  // count of forced-one base bits below each register field
  localparam int SPR_ONES  = 7;
  localparam int PGEN_ONES = 11;
  localparam int COLR_ONES = 5;
  localparam int BMP4_ONES = 10;
  localparam int BMP8_ONES = 11;

  // register field widths derived from the address width
  localparam int NAME_RW    = ADDR_W - BMP4_ONES;
  localparam int NAME8_RW   = ADDR_W - BMP8_ONES;
  localparam int PGEN_RW    = ADDR_W - PGEN_ONES;
  localparam int COLR_HI_RW = 3;
  localparam int COLR_LO_RW = ADDR_W - COLR_ONES - COLR_HI_RW;
  localparam int SPR_HI_RW  = 2;
  localparam int SPR_LO_RW  = ADDR_W - SPR_ONES - SPR_HI_RW;

  // fixed-zero bits in the padded index word
  localparam logic [ADDR_W-1:0] SATR_ZERO = 17'h00180;
  localparam logic [ADDR_W-1:0] SCOL_ZERO = 17'h00200;
endpackage

// File: rtl/vtab_index_pad.sv
module vtab_index_pad
  import vtab_pkg::*;
(
  input  logic [1:0]        mode_i,
  input  logic [2:0]        tbl_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] pad_o,
  output logic              ok_o
);
  logic [ADDR_W-1:0] idx_x;
  logic [ADDR_W-1:0] zero_m;
  int                iw;

  assign idx_x = {{(ADDR_W-IDX_W){1'b0}}, idx_i};

  always_comb begin
    ok_o   = 1'b1;
    iw     = 0;
    zero_m = '0;
    unique case (tbl_i)
      TB_SATR: begin iw = SATR_IW; zero_m = SATR_ZERO; end
      TB_SCOL: begin iw = SCOL_IW; zero_m = SCOL_ZERO; end
      TB_PGEN, TB_COLR: begin
        if (mode_i == MD_TILE_A || mode_i == MD_TILE_B) iw = TILE_IW;
        else ok_o = 1'b0;
      end
      TB_NAME: begin
        if (mode_i == MD_BMP4)      iw = BMP4_IW;
        else if (mode_i == MD_BMP8) iw = BMP8_IW;
        else ok_o = 1'b0;
      end
      default: ok_o = 1'b0;
    endcase
  end

  always_comb begin
    for (int b = 0; b < ADDR_W; b++) begin
      pad_o[b] = (b < iw) ? idx_x[b] : 1'b1;
    end
    pad_o = pad_o & ~zero_m;
  end
endmodule

// File: rtl/vtab_base_pack.sv
module vtab_base_pack
  import vtab_pkg::*;
(
  input  logic [1:0]            mode_i,
  input  logic [2:0]            tbl_i,
  input  logic [NAME_RW-1:0]    name_base_i,
  input  logic [PGEN_RW-1:0]    pat_base_i,
  input  logic [COLR_LO_RW-1:0] col_lo_i,
  input  logic [COLR_HI_RW-1:0] col_hi_i,
  input  logic [SPR_LO_RW-1:0]  spr_lo_i,
  input  logic [SPR_HI_RW-1:0]  spr_hi_i,
  output logic [ADDR_W-1:0]     base_o
);
  always_comb begin
    base_o = '1;
    unique case (tbl_i)
      TB_SATR, TB_SCOL: base_o = {spr_hi_i, spr_lo_i, {SPR_ONES{1'b1}}};
      TB_PGEN:          base_o = {pat_base_i, {PGEN_ONES{1'b1}}};
      TB_COLR:          base_o = {col_hi_i, col_lo_i, {COLR_ONES{1'b1}}};
      TB_NAME: begin
        if (mode_i == MD_BMP8)
          base_o = {name_base_i[NAME8_RW-1:0], {BMP8_ONES{1'b1}}};
        else
          base_o = {name_base_i, {BMP4_ONES{1'b1}}};
      end
      default: base_o = '1;
    endcase
  end
endmodule

// File: rtl/vtab_addr_unit.sv
module vtab_addr_unit
  import vtab_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  req_i,
  input  logic [1:0]            mode_i,
  input  logic [2:0]            tbl_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [NAME_RW-1:0]    name_base_i,
  input  logic [PGEN_RW-1:0]    pat_base_i,
  input  logic [COLR_LO_RW-1:0] col_lo_i,
  input  logic [COLR_HI_RW-1:0] col_hi_i,
  input  logic [SPR_LO_RW-1:0]  spr_lo_i,
  input  logic [SPR_HI_RW-1:0]  spr_hi_i,
  output logic                  valid_o,
  output logic                  err_o,
  output logic [ADDR_W-1:0]     addr_o
);
  logic [ADDR_W-1:0] pad_w;
  logic [ADDR_W-1:0] base_w;
  logic [ADDR_W-1:0] and_w;
  logic              ok_w;

  vtab_index_pad u_pad (
    .mode_i (mode_i),
    .tbl_i  (tbl_i),
    .idx_i  (idx_i),
    .pad_o  (pad_w),
    .ok_o   (ok_w)
  );

  vtab_base_pack u_base (
    .mode_i      (mode_i),
    .tbl_i       (tbl_i),
    .name_base_i (name_base_i),
    .pat_base_i  (pat_base_i),
    .col_lo_i    (col_lo_i),
    .col_hi_i    (col_hi_i),
    .spr_lo_i    (spr_lo_i),
    .spr_hi_i    (spr_hi_i),
    .base_o      (base_w)
  );

  // per-bit masking stage; an unsupported pair gates every bit to zero
  for (genvar g = 0; g < ADDR_W; g++) begin : g_mask
    assign and_w[g] = pad_w[g] & base_w[g] & ok_w;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      addr_o  <= '0;
    end else begin
      valid_o <= req_i;
      err_o   <= req_i & ~ok_w;
      if (req_i) addr_o <= and_w;
    end
  end

  p_req_valid_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    req_i |=> valid_o);
  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    !req_i |=> (!valid_o && !err_o));
  p_satr_gap_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (req_i && tbl_i == TB_SATR) |=> (addr_o[8:7] == 2'b00 && !err_o));
  p_scol_gap_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (req_i && tbl_i == TB_SCOL) |=> (!addr_o[9] && !err_o));
  p_pgen_low_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (req_i && tbl_i == TB_PGEN && mode_i[1] == 1'b0)
      |=> (addr_o[10:0] == $past(idx_i[10:0])));
  p_name4_low_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (req_i && tbl_i == TB_NAME && mode_i == MD_BMP4)
      |=> (addr_o[9:0] == $past(idx_i[9:0])));
  p_err_zero_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    err_o |-> (valid_o && addr_o == '0));
endmodule

// File: tb/vtab_addr_unit_tb.sv
`timescale 1ns/1ps
module vtab_addr_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        req;
  logic [1:0]  mode;
  logic [2:0]  tbl;
  logic [15:0] idx;
  logic [6:0]  nameb;
  logic [5:0]  patb;
  logic [8:0]  clo;
  logic [2:0]  chi;
  logic [7:0]  slo;
  logic [1:0]  shi;
  logic        valid, err;
  logic [16:0] addr;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  vtab_addr_unit u_dut (
    .clk_i(clk), .rst_i(rst), .req_i(req), .mode_i(mode), .tbl_i(tbl),
    .idx_i(idx), .name_base_i(nameb), .pat_base_i(patb), .col_lo_i(clo),
    .col_hi_i(chi), .spr_lo_i(slo), .spr_hi_i(shi),
    .valid_o(valid), .err_o(err), .addr_o(addr)
  );

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // arithmetic model: returns -1 for an unsupported pair
  function automatic int model(int m, int t, int ix);
    int iw, lo, rv, zm, inner, base;
    zm = 0; iw = 0; lo = 0; rv = 0;
    case (t)
      3: begin iw = 7; zm = 'h180; lo = 7; rv = shi * 256 + slo; end
      4: begin iw = 9; zm = 'h200; lo = 7; rv = shi * 256 + slo; end
      1: if (m < 2) begin iw = 13; lo = 11; rv = patb; end else return -1;
      2: if (m < 2) begin iw = 13; lo = 5; rv = chi * 512 + clo; end else return -1;
      0: if (m == 2) begin iw = 15; lo = 10; rv = nameb; end
         else if (m == 3) begin iw = 16; lo = 11; rv = nameb % 64; end
         else return -1;
      default: return -1;
    endcase
    inner = (('h1FFFF >> iw) << iw) | (ix & ((1 << iw) - 1));
    inner = inner & ~zm;
    base  = (rv << lo) | ((1 << lo) - 1);
    return inner & base & 'h1FFFF;
  endfunction

  function automatic string tag(int m, int t);
    if (model(m, t, 0) < 0) return "R10";
    case (t)
      3: return "R3";
      4: return "R4";
      1: return "R6";
      2: return "R7";
      default: return (m == 2) ? "R8" : "R9";
    endcase
  endfunction

  task automatic lookup(input int m, input int t, input int ix);
    @(negedge clk);
    mode = 2'(m); tbl = 3'(t); idx = 16'(ix); req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic set_regs(input int k);
    case (k)
      0: begin nameb = '1; patb = '1; clo = '1; chi = '1; slo = '1; shi = '1; end
      1: begin nameb = 7'h55; patb = 6'h2A; clo = 9'h155; chi = 3'h5; slo = 8'hA5; shi = 2'h2; end
      default: begin nameb = 7'h3C; patb = 6'h19; clo = 9'h0E7; chi = 3'h3; slo = 8'h5B; shi = 2'h1; end
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int a1, a2, a3, a4;
    int ids[8] = '{0, 'h7F, 'h80, 'h1FF, 'h1234, 'hFFFF, 'h5555, 'hAAAA};
    rst = 1'b1; req = 1'b0; mode = '0; tbl = '0; idx = '0;
    set_regs(0);
    repeat (3) @(negedge clk);
    chk("R1 valid", valid, 0);
    chk("R1 err", err, 0);
    chk("R1 addr", addr, 0);
    rst = 1'b0;

    // full sweep across modes, tables, indices and register patterns
    for (int k = 0; k < 3; k++) begin
      set_regs(k);
      for (int m = 0; m < 4; m++)
        for (int t = 0; t < 8; t++)
          for (int i = 0; i < 8; i++) begin
            int e;
            e = model(m, t, ids[i]);
            lookup(m, t, ids[i]);
            chk("R2 valid", valid, 1);
            chk({tag(m, t), " err"}, err, (e < 0) ? 1 : 0);
            chk({tag(m, t), " addr"}, addr, (e < 0) ? 0 : e);
          end
    end

    // R2: no request leaves valid low
    @(negedge clk);
    chk("R2 idle valid", valid, 0);
    chk("R2 idle err", err, 0);

    // R5: A9 cleared, A8/A7 set -> attribute overlaps colour table
    shi = 2'b11; slo = 8'b1111_1011;
    lookup(2, 3, 'h2A); a1 = addr;
    lookup(2, 4, 'h2A); a2 = addr;
    chk("R5 overlap", a1, a2);
    chk("R5 value", a1, 'h1FC2A);

    // R4: A8/A7 cleared -> colour groups of 8 sprites mirror
    slo = 8'b1111_1100;
    lookup(0, 4, 'h013); a1 = addr;
    lookup(0, 4, 'h093); a2 = addr;
    lookup(0, 4, 'h113); a3 = addr;
    lookup(0, 4, 'h193); a4 = addr;
    chk("R4 mirror 1", a2, a1);
    chk("R4 mirror 2", a3, a1);
    chk("R4 mirror 3", a4, a1);

    // R6: A12/A11 cleared -> four pattern tables fold into one
    patb = 6'b111100;
    lookup(1, 1, 'h0321); a1 = addr;
    lookup(1, 1, 'h0B21); a2 = addr;
    lookup(1, 1, 'h1321); a3 = addr;
    lookup(1, 1, 'h1B21); a4 = addr;
    chk("R6 fold 1", a2, a1);
    chk("R6 fold 2", a3, a1);
    chk("R6 fold 3", a4, a1);
    chk("R6 value", a1, 'h1E321);

    // R9: bit 6 of the name register ignored in 8-bit bitmap mode
    nameb = 7'h7F;
    lookup(3, 0, 'h4567); a1 = addr;
    nameb = 7'h3F;
    lookup(3, 0, 'h4567); a2 = addr;
    chk("R9 shifted", a1, a2);

    // R11: index bits above the width have no effect
    set_regs(0);
    lookup(0, 3, 'h0055); a1 = addr;
    lookup(0, 3, 'hFF55); a2 = addr;
    chk("R11 satr", a2, a1);
    lookup(2, 0, 'h0123); a1 = addr;
    lookup(2, 0, 'h8123); a2 = addr;
    chk("R11 name4", a2, a1);

    // R1: reset after activity
    lookup(0, 3, 'h7F);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 re-reset valid", valid, 0);
    chk("R1 re-reset addr", addr, 0);
    rst = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule